// File: doc/BRIEF.md
# NRZI Per-Word Header Aligner

This receiver block takes a serial line bit qualified by a strobe, undoes the NRZI line coding, and finds word boundaries in the decoded stream. Every word on the line is 30 bits long and opens with a fixed five-bit header, so the block can regain word alignment from any single correctly received header followed by a second one exactly one word later. Once aligned, it delivers the 25 payload bits of each word as a parallel word with a one-cycle valid pulse.

Alongside alignment, the block watches the raw line for runs of identical bits longer than the permitted maximum and flags each offending bit. A header missing from its expected slot while aligned is reported, alignment is dropped and the search restarts on the very next bit, so a slipped or corrupted stream is recovered within about one word.

Top module: `nrzi_word_aligner`

## Requirements
- R1: After reset, `payload_vld`, `locked`, `hdr_err` and `run_err` are all 0.
- R2: A decoded bit is 1 when the line bit differs from the previous line bit and 0 when it is equal; the previous-line-bit register starts at 0 after reset.
- R3: The header is the decoded sequence 0,0,0,1,1 (oldest first). It is searched for on every strobed bit; `locked` rises only when a second header ends exactly 30 strobed bits after the first, one clock after the strobe that completes it, and a missing second header silently restarts the search.
- R4: `payload` holds the 25 decoded bits that followed a header, the earliest received in bit 24, presented with a one-clock `payload_vld` pulse one clock after the strobe that completes the next header.
- R5: `payload_vld` pulses only while `locked` is 1, and the word that completes lock acquisition is never reported.
- R6: While locked, a header absent at the expected boundary gives a one-clock `hdr_err` pulse and clears `locked`, both one clock after the strobe of the 30th bit.
- R7: After a header error, header search resumes on the next strobed bit, so a header that overlaps the failed slot can begin a new lock.
- R8: `run_err` pulses one clock after every strobed line bit that extends a run of identical line bits beyond 4.
- R9: Clocks with `bit_stb` low change no state: no pulse appears on `payload_vld`, `hdr_err` or `run_err` and `locked` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial line bit (NRZI coded) |
| bit_stb | input | 1 | Qualifies `bit_in` for one clock |
| payload | output | 25 | Payload of the last complete word, earliest bit in MSB |
| payload_vld | output | 1 | One-clock pulse marking a new `payload` |
| locked | output | 1 | Word alignment held |
| hdr_err | output | 1 | One-clock pulse: header missing while locked |
| run_err | output | 1 | One-clock pulse: line run longer than 4 |

## Verification
Every result is registered once behind the strobe, so the bench drives a bit on a falling edge, lets one rising edge pass and samples all outputs on the following falling edge, where each pulse belonging to that bit must be present. The pulses and lock transitions are expected on specific header bits (the fifth header bit for lock, payload and normal header errors, the fourth for a one-bit slip), and every other bit is checked to carry no pulse. Idle clocks inserted between strobes are each checked for silence one clock later, and run errors are predicted by a run counter over the encoded line bits the bench itself produced.

// File: rtl/word_align_pkg.sv
package word_align_pkg;
   typedef enum logic [1:0] {
      ST_HUNT    = 2'd0,
      ST_CONFIRM = 2'd1,
      ST_LOCKED  = 2'd2
   } align_state_t;
endpackage

// File: rtl/nrzi_decoder.sv
module nrzi_decoder (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic line_bit,
   output logic data_bit,
   output logic same_as_prev
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   prev_q <= 1'b0;
      else if (stb) prev_q <= line_bit;
   end

   assign data_bit     = line_bit ^ prev_q;
   assign same_as_prev = ~data_bit;
endmodule

// File: rtl/run_limit_check.sv
module run_limit_check #(
   parameter int MAX_RUN = 4,
   parameter bit ENABLE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic same_as_prev,
   output logic run_err
);
   localparam int RUN_W = $clog2(MAX_RUN + 2);
   localparam logic [RUN_W-1:0] SAT = RUN_W'(MAX_RUN + 1);
   localparam logic [RUN_W-1:0] LIM = RUN_W'(MAX_RUN);

   generate
      if (ENABLE) begin : g_check
         logic [RUN_W-1:0] run_q;
         logic             err_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q <= '0;
               err_q <= 1'b0;
            end else begin
               err_q <= 1'b0;
               if (stb) begin
                  if (same_as_prev) begin
                     run_q <= (run_q == SAT) ? SAT : run_q + RUN_W'(1);
                     err_q <= (run_q >= LIM);
                  end else begin
                     run_q <= RUN_W'(1);
                  end
               end
            end
         end
         assign run_err = err_q;
      end else begin : g_nocheck
         assign run_err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
   import word_align_pkg::*;
#(
   parameter int                WORD_BITS   = 30,
   parameter int                HDR_BITS    = 5,
   parameter logic [HDR_BITS-1:0] HDR_PATTERN = 5'b00011
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          stb,
   input  logic                          data_bit,
   output logic [WORD_BITS-HDR_BITS-1:0] payload,
   output logic                          payload_vld,
   output logic                          locked,
   output logic                          hdr_err
);
   localparam int PAY_BITS = WORD_BITS - HDR_BITS;
   localparam int CNT_W    = $clog2(WORD_BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

   align_state_t            state_q;
   logic [CNT_W-1:0]        cnt_q;
   logic [WORD_BITS-2:0]    shreg_q;
   logic [WORD_BITS-1:0]    shreg_n;
   logic [PAY_BITS-1:0]     pay_q;
   logic                    vld_q;
   logic                    herr_q;
   logic                    hdr_hit;
   logic                    at_boundary;

   assign shreg_n     = {shreg_q, data_bit};
   assign hdr_hit     = (shreg_n[HDR_BITS-1:0] == HDR_PATTERN);
   assign at_boundary = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         cnt_q   <= '0;
         shreg_q <= '0;
         pay_q   <= '0;
         vld_q   <= 1'b0;
         herr_q  <= 1'b0;
      end else begin
         vld_q  <= 1'b0;
         herr_q <= 1'b0;
         if (stb) begin
            shreg_q <= shreg_n[WORD_BITS-2:0];
            case (state_q)
               ST_HUNT: begin
                  if (hdr_hit) begin
                     state_q <= ST_CONFIRM;
                     cnt_q   <= '0;
                  end
               end
               ST_CONFIRM: begin
                  if (at_boundary) begin
                     cnt_q   <= '0;
                     state_q <= hdr_hit ? ST_LOCKED : ST_HUNT;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               ST_LOCKED: begin
                  if (at_boundary) begin
                     cnt_q <= '0;
                     if (hdr_hit) begin
                        vld_q <= 1'b1;
                        pay_q <= shreg_n[WORD_BITS-1:HDR_BITS];
                     end else begin
                        herr_q  <= 1'b1;
                        state_q <= ST_HUNT;
                     end
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end

   assign payload     = pay_q;
   assign payload_vld = vld_q;
   assign locked      = (state_q == ST_LOCKED);
   assign hdr_err     = herr_q;
endmodule

// File: rtl/nrzi_word_aligner.sv
module nrzi_word_aligner #(
   parameter int                  WORD_BITS   = 30,
   parameter int                  HDR_BITS    = 5,
   parameter logic [HDR_BITS-1:0] HDR_PATTERN = 5'b00011,
   parameter int                  MAX_RUN     = 4,
   parameter bit                  RUN_CHECK   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bit_in,
   input  logic                          bit_stb,
   output logic [WORD_BITS-HDR_BITS-1:0] payload,
   output logic                          payload_vld,
   output logic                          locked,
   output logic                          hdr_err,
   output logic                          run_err
);
   generate
      if (HDR_BITS < 1 || HDR_BITS >= WORD_BITS) begin : g_bad_hdr
         $error("HDR_BITS must lie between 1 and WORD_BITS-1");
      end
      if (MAX_RUN < 1) begin : g_bad_run
         $error("MAX_RUN must be at least 1");
      end
   endgenerate

   logic dec_bit;
   logic same_bit;

   nrzi_decoder u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .stb          (bit_stb),
      .line_bit     (bit_in),
      .data_bit     (dec_bit),
      .same_as_prev (same_bit)
   );

   run_limit_check #(
      .MAX_RUN (MAX_RUN),
      .ENABLE  (RUN_CHECK)
   ) u_run (
      .clk          (clk),
      .rst_n        (rst_n),
      .stb          (bit_stb),
      .same_as_prev (same_bit),
      .run_err      (run_err)
   );

   frame_aligner #(
      .WORD_BITS   (WORD_BITS),
      .HDR_BITS    (HDR_BITS),
      .HDR_PATTERN (HDR_PATTERN)
   ) u_align (
      .clk         (clk),
      .rst_n       (rst_n),
      .stb         (bit_stb),
      .data_bit    (dec_bit),
      .payload     (payload),
      .payload_vld (payload_vld),
      .locked      (locked),
      .hdr_err     (hdr_err)
   );
endmodule

// File: rtl/nrzi_word_aligner_chk.sv
module nrzi_word_aligner_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_stb,
   input logic payload_vld,
   input logic locked,
   input logic hdr_err,
   input logic run_err
);
   assert_vld_when_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      payload_vld |-> locked);

   assert_herr_drops_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_err |-> (!locked && $past(locked)));

   assert_no_vld_with_herr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(payload_vld && hdr_err));

   assert_vld_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      payload_vld |-> $past(bit_stb));

   assert_runerr_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run_err |-> $past(bit_stb));

   assert_lock_rise_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(bit_stb));

   assert_lock_holds_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_stb) |-> $stable(locked));
endmodule

bind nrzi_word_aligner nrzi_word_aligner_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_stb     (bit_stb),
   .payload_vld (payload_vld),
   .locked      (locked),
   .hdr_err     (hdr_err),
   .run_err     (run_err)
);

// File: tb/nrzi_word_aligner_tb_top.sv
module nrzi_word_aligner_tb_top;
   localparam logic [24:0] PAY_MASK = 25'b1001001001001001001001001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_in = 1'b0;
   logic        bit_stb = 1'b0;
   logic [24:0] payload;
   logic        payload_vld, locked, hdr_err, run_err;

   int vectors = 0;
   int misses  = 0;
   int gap_cycles = 0;
   logic line_prev = 1'b0;
   int   run_len = 0;
   bit   finished = 1'b0;

   always #10 clk = ~clk;

   nrzi_word_aligner dut_i (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
      .payload(payload), .payload_vld(payload_vld), .locked(locked),
      .hdr_err(hdr_err), .run_err(run_err)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [24:0] pay_of(input int i);
      return (25'(i) * 25'h0ABCDE + 25'h13579) | PAY_MASK;
   endfunction

   task automatic send_line(input logic lb, input bit e_vld, input logic [24:0] e_pay,
                            input bit e_lock, input bit e_herr);
      bit e_run;
      if (lb == line_prev) run_len++; else run_len = 1;
      e_run = (run_len > 4);
      line_prev = lb;
      @(negedge clk);
      bit_in  = lb;
      bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
      check("R4", "payload_vld", 32'(payload_vld), 32'(e_vld));
      if (e_vld) check("R4", "payload", 32'(payload), 32'(e_pay));
      check("R3", "locked", 32'(locked), 32'(e_lock));
      check("R6", "hdr_err", 32'(hdr_err), 32'(e_herr));
      check("R8", "run_err", 32'(run_err), 32'(e_run));
      for (int g = 0; g < gap_cycles; g++) begin
         @(negedge clk);
         check("R9", "idle vld", 32'(payload_vld), 32'd0);
         check("R9", "idle herr", 32'(hdr_err), 32'd0);
         check("R9", "idle run", 32'(run_err), 32'd0);
         check("R9", "idle lock", 32'(locked), 32'(e_lock));
      end
   endtask

   // R2: line bit toggles for a decoded 1
   task automatic send_data(input logic db, input bit e_vld, input logic [24:0] e_pay,
                            input bit e_lock, input bit e_herr);
      send_line(line_prev ^ db, e_vld, e_pay, e_lock, e_herr);
   endtask

   task automatic send_word(input logic [4:0] hdr, input logic [24:0] pay,
                            input int herr_at, input bit vld_end,
                            input logic [24:0] e_pay, input bit lock_before,
                            input bit lock_end);
      for (int i = 0; i < 5; i++) begin
         bit lk;
         if (herr_at >= 0 && i >= herr_at) lk = (i == 4) ? lock_end : 1'b0;
         else lk = (i == 4) ? lock_end : lock_before;
         send_data(hdr[4-i], (i == 4) && vld_end, e_pay, lk, (i == herr_at));
      end
      for (int i = 24; i >= 0; i--) send_data(pay[i], 1'b0, '0, lock_end, 1'b0);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         misses++;
         vectors++;
         $display("FAIL watchdog: actual running expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "vld", 32'(payload_vld), 32'd0);
      check("R1", "locked", 32'(locked), 32'd0);
      check("R1", "herr", 32'(hdr_err), 32'd0);
      check("R1", "run", 32'(run_err), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 / R2: six equal line bits starting from reset value 0
      for (int i = 0; i < 6; i++) send_line(1'b0, 1'b0, '0, 1'b0, 1'b0);
      // filler that cannot form a header
      send_data(1'b1, 0, '0, 0, 0); send_data(1'b0, 0, '0, 0, 0);
      send_data(1'b1, 0, '0, 0, 0); send_data(1'b0, 0, '0, 0, 0);
      for (int i = 0; i < 4; i++) send_data(1'b1, 0, '0, 0, 0);

      // R3, R5: acquisition, first word not reported
      send_word(5'b00011, pay_of(0), -1, 0, '0, 0, 0);
      send_word(5'b00011, pay_of(1), -1, 0, '0, 0, 1);
      // R4: payload of previous word, MSB first
      send_word(5'b00011, pay_of(2), -1, 1, pay_of(1), 1, 1);
      gap_cycles = 2; // R9
      send_word(5'b00011, pay_of(3), -1, 1, pay_of(2), 1, 1);
      gap_cycles = 0;
      send_word(5'b00011, pay_of(4), -1, 1, pay_of(3), 1, 1);

      // R6: corrupted header while locked
      send_word(5'b00111, pay_of(5), 4, 0, '0, 1, 0);
      send_word(5'b00011, pay_of(6), -1, 0, '0, 0, 0);
      send_word(5'b00011, pay_of(7), -1, 0, '0, 0, 1);
      send_word(5'b00011, pay_of(8), -1, 1, pay_of(7), 1, 1);

      // R7: one-bit slip, error on 4th header bit, header restarts confirm
      send_data(1'b1, 0, '0, 1, 0);
      send_word(5'b00011, pay_of(9), 3, 0, '0, 1, 0);
      send_word(5'b00011, pay_of(10), -1, 0, '0, 0, 1);
      send_word(5'b00011, pay_of(11), -1, 1, pay_of(10), 1, 1);

      // R3: second header one bit late during confirm gives no lock
      send_word(5'b01011, pay_of(12), 4, 0, '0, 1, 0);
      send_word(5'b00011, pay_of(13), -1, 0, '0, 0, 0);
      send_data(1'b1, 0, '0, 0, 0);
      send_word(5'b00011, pay_of(14), -1, 0, '0, 0, 0);
      send_word(5'b00011, pay_of(15), -1, 0, '0, 0, 1);
      send_word(5'b00011, pay_of(16), -1, 1, pay_of(15), 1, 1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule